// File: doc/BRIEF.md
# Video Pixel Serializer

This block turns one fetched display byte into a stream of single-bit pixel levels, one pixel per pixel-clock edge. The pixel clock runs at twice the processor clock, 6.5 MHz in the target system. The character fetch logic pulses a one-cycle load strobe near the end of its refresh window. With that strobe it presents the byte and an invert flag. If the flag is set, the byte is complemented as it is captured. The captured bits then leave the register one per clock, starting with the most significant bit.

Every vacated position is refilled with the white (high) level. The output therefore goes back to white on its own eight pixels after the last load, and it stays white until a new byte arrives. Two blanking inputs, horizontal sync and back porch, force the output to white whenever either is high. The shift register keeps advancing underneath while the output is forced. The load strobe is a plain control pin with no back-pressure: the register accepts every strobe in the cycle it is seen. A strobe that arrives while earlier pixels are still leaving discards those pixels.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is held and after it is released, with no load and no blanking, the pixel output is white (1).
- R2: After a clock edge at which the load strobe is high and invert is low, the output shows bit 7 of the byte on the following cycle, then bits 6 down to 0 on the next seven cycles.
- R3: After a clock edge at which both the load strobe and invert are high, the output shows the complement of each data bit, in the same order as R2.
- R4: On the ninth cycle after a load and on every later cycle without a new load, the output is white (1).
- R5: While the horizontal sync input is high, the output is white (1), whatever bits are held.
- R6: While the back-porch input is high, the output is white (1), whatever bits are held. The register keeps shifting under R5 and R6 blanking.
- R7: A load on the same edge as a pending shift wins: the new byte's bit 7 appears on the next cycle, and the old byte's remaining bits are discarded.
- R8: The invert and data inputs are ignored on edges where the load strobe is low, so changing them during the eight pixel cycles does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset; fills the register with white |
| load_i | input | 1 | One-cycle parallel load strobe |
| invert_i | input | 1 | Complement the byte at load time when high |
| data_i | input | 8 | Display byte to be serialized |
| hsync_i | input | 1 | Horizontal sync blanking, forces white |
| porch_i | input | 1 | Back-porch blanking, forces white |
| pix_o | output | 1 | Serial pixel level, 1 = white |

## Verification
Four behaviours are checked on every cycle: blanking by either input forces white, the first pixel after a plain or inverted load matches the captured bit 7, and the output is white once eight cycles have passed since the last load. Only the bench scenarios show the full eight-pixel order for every byte value in both polarities. They also show that the register keeps advancing while blanked, that a second load cuts off the first byte, that invert and data are ignored between loads, and that reset in mid-byte restores white.

// File: rtl/pixshift_pkg.sv
package pixshift_pkg;
  // level driven when nothing is to be shown
  localparam logic WHITE = 1'b1;
  // shared view of the blanking controls
  typedef struct packed {
    logic hsync;
    logic porch;
  } blank_t;
endpackage

// File: rtl/pix_load_mux.sv
module pix_load_mux #(
  parameter int DW = 8
) (
  input  logic          invert_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] ld_val_o
);
  // polarity is fixed at capture time, not on the serial side
  always_comb begin
    ld_val_o = invert_i ? ~data_i : data_i;
  end
endmodule

// File: rtl/pix_shift_core.sv
module pix_shift_core
  import pixshift_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic          msb_o
);
  logic [DW-1:0] sr_q;

  // one flop per stage; bit 0 is refilled with white on each shift
  for (genvar g = 0; g < DW; g++) begin : g_stage
    logic nxt;
    if (g == 0) begin : g_fill
      always_comb nxt = ld_i ? ld_val_i[g] : WHITE;
    end else begin : g_link
      always_comb nxt = ld_i ? ld_val_i[g] : sr_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) sr_q[g] <= WHITE;
      else        sr_q[g] <= nxt;
    end
  end

  assign msb_o = sr_q[DW-1];
endmodule

// File: rtl/pix_blank_gate.sv
module pix_blank_gate
  import pixshift_pkg::*;
(
  input  blank_t blank_i,
  input  logic   pix_i,
  output logic   pix_o
);
  always_comb begin
    pix_o = (blank_i.hsync || blank_i.porch) ? WHITE : pix_i;
  end
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixshift_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          invert_i,
  input  logic [DW-1:0] data_i,
  input  logic          hsync_i,
  input  logic          porch_i,
  output logic          pix_o
);
  logic [DW-1:0] ld_val;
  logic          core_bit;
  blank_t        blank;

  assign blank.hsync = hsync_i;
  assign blank.porch = porch_i;

  pix_load_mux #(.DW(DW)) u_mux (
    .invert_i (invert_i),
    .data_i   (data_i),
    .ld_val_o (ld_val)
  );

  pix_shift_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_i),
    .ld_val_i (ld_val),
    .msb_o    (core_bit)
  );

  pix_blank_gate u_gate (
    .blank_i (blank),
    .pix_i   (core_bit),
    .pix_o   (pix_o)
  );
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic          invert_i,
  input logic [DW-1:0] data_i,
  input logic          hsync_i,
  input logic          porch_i,
  input logic          pix_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] IDLE = CW'(DW);

  // cycles since the last accepted load, saturating at DW
  logic [CW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      age_q <= IDLE;
    else if (load_i) age_q <= '0;
    else if (age_q != IDLE) age_q <= age_q + 1'b1;
  end

  p_hsync_white_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |-> pix_o);

  p_porch_white_r6: assert property (@(posedge clk) disable iff (!rst_n)
    porch_i |-> pix_o);

  p_plain_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !invert_i) |=> (hsync_i || porch_i || pix_o == $past(data_i[DW-1])));

  p_invert_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && invert_i) |=> (hsync_i || porch_i || pix_o == !$past(data_i[DW-1])));

  p_idle_white_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == IDLE && !hsync_i && !porch_i) |-> pix_o);
endmodule

bind pixel_serializer pixel_serializer_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .invert_i (invert_i),
  .data_i   (data_i),
  .hsync_i  (hsync_i),
  .porch_i  (porch_i),
  .pix_o    (pix_o)
);

// File: tb/pixel_serializer_tb_top.sv
`timescale 1ns/1ps
module pixel_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic       invert_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       hsync_i = 1'b0;
  logic       porch_i = 1'b0;
  logic       pix_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixel_serializer #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .invert_i(invert_i),
    .data_i(data_i), .hsync_i(hsync_i), .porch_i(porch_i), .pix_o(pix_o)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pix_o !== exp) begin
      errors++;
      $display("FAIL %s: pix_o=%b expected %b at %0t", req, pix_o, exp, $time);
    end
  endtask

  // set inputs after a falling edge, then let them settle before sampling
  task automatic cyc(input logic ld, input logic inv, input logic [7:0] d,
                     input logic hs, input logic bp);
    @(negedge clk);
    load_i = ld; invert_i = inv; data_i = d; hsync_i = hs; porch_i = bp;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cyc(0, 0, 8'h00, 0, 0);
    chk(1'b1, "R1 in reset");
    repeat (2) cyc(0, 0, 8'h00, 0, 0);
    rst_n = 1'b1;
    repeat (3) begin
      cyc(0, 0, 8'h00, 0, 0);
      chk(1'b1, "R1 after reset");
    end

    // R2/R3/R4/R8: every byte in both polarities; invert and data
    // are scrambled on the non-load cycles
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] img;
        img = (inv != 0) ? ~8'(v) : 8'(v);
        cyc(1, inv[0], 8'(v), 0, 0);
        for (int k = 0; k < 8; k++) begin
          cyc(0, ~inv[0], ~8'(v) ^ 8'(k * 37), 0, 0);
          chk(img[7 - k], (inv != 0) ? "R3/R8 inverted bit" : "R2/R8 plain bit");
        end
        cyc(0, inv[0], 8'h00, 0, 0);
        chk(1'b1, "R4 white after eight pixels");
      end
    end

    // R4: stays white over a longer idle stretch
    repeat (12) begin
      cyc(0, 1, 8'h00, 0, 0);
      chk(1'b1, "R4 idle white");
    end

    // R5/R6: blanking forces white and shifting continues underneath
    cyc(1, 0, 8'h0F, 0, 0);
    for (int k = 0; k < 8; k++) begin
      logic hs, bp, e;
      hs = (k == 1) || (k == 5);
      bp = (k == 2) || (k == 6);
      cyc(0, 0, 8'h00, hs, bp);
      e = (hs || bp) ? 1'b1 : ((k >= 4) ? 1'b1 : 1'b0);
      chk(e, hs ? "R5 hsync white" : (bp ? "R6 porch white" : "R6 shift under blank"));
    end
    // blanking over an all-black byte, both inputs together
    cyc(1, 1, 8'hFF, 0, 0);
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, 8'h00, k[0], k[1]);
      chk((k[0] || k[1]) ? 1'b1 : 1'b0, "R5/R6 blank over black");
    end

    // R7: second load cuts the first byte short
    cyc(1, 0, 8'h00, 0, 0);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 8'h00, 0, 0);
      chk(1'b0, "R7 first byte");
    end
    cyc(1, 0, 8'hA5, 0, 0);
    chk(1'b0, "R7 first byte before reload");
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, 8'h00, 0, 0);
      chk(8'hA5 >> (7 - k) & 1'b1, "R7 second byte bit");
    end
    cyc(0, 0, 8'h00, 0, 0);
    chk(1'b1, "R7/R4 white after second byte");

    // R1: reset in mid-byte restores white
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 0, 8'h00, 0, 0);
    chk(1'b0, "R1 black before reset");
    rst_n = 1'b0;
    cyc(0, 0, 8'h00, 0, 0);
    chk(1'b1, "R1 reset mid-byte");
    rst_n = 1'b1;
    cyc(0, 0, 8'h00, 0, 0);
    chk(1'b1, "R1 white after reset");

    finish_run();
  end
endmodule